// File: doc/BRIEF.md
# DMA Channel Address and Terminal Count Unit

This block keeps the per-channel transfer parameters of a four-channel DMA engine. Each channel has a 16-bit transfer address and a 16-bit count register. The lower 14 bits of the count register hold a cycle count, and the upper 2 bits hold an operation code. An outside arbiter reports each completed transfer with a per-channel strobe. When a channel is enabled, that strobe moves its address forward by one and lowers its cycle count by one. When the strobe arrives while the count is already zero, the transfer is the channel's last one: the block records the event in a status register and switches the channel off.

Software loads the registers one byte at a time through a small register port, using a shared low/high byte toggle. Channel 2 can be set to auto-reload. In that mode, finishing channel 2 copies channel 3's address and count into it, and channel 2 stays enabled. An update flag in the status register marks that the copy happened. A channel selector picks which channel's address, operation code and terminal-count indication appear on the outputs.

Top module: `dma_tc_unit`

## Requirements
- R1: After synchronous reset, all address and count registers, the enables, the auto-reload bit, the status bits and the byte toggle are zero, and `tc_out` is low.
- R2: `reg_sel` values 0 to 7 address channel `reg_sel[2:1]`: the address register when `reg_sel[0]`=0 and the count register when `reg_sel[0]`=1. A write or a read at these values transfers the low byte when the toggle is 0 and the high byte when it is 1, and then flips the toggle.
- R3: A write at `reg_sel`=8 is the mode write. It clears the byte toggle, sets the channel enables from `wdata[3:0]` and sets auto-reload from `wdata[4]`.
- R4: A `cycle_done` strobe on an enabled channel adds one to that channel's address. If the 14-bit count is nonzero, it also subtracts one from the count. Operation-code bits [15:14] stay unchanged.
- R5: Loading N-1 into the count gives exactly N cycles. `tc_out` is high for the selected enabled channel while its count is zero. The Nth strobe sets that channel's status bit and disables the channel.
- R6: `cur_op` shows bits [15:14] of the selected channel's count register. The encoding is 00 verify, 01 write to memory, 10 read from memory, 11 illegal.
- R7: A read at `reg_sel`=8 returns terminal-count bits in [3:0] and the update flag in bit 4, and clears the terminal-count bits at that clock edge. A terminal count occurring in the same cycle as the read is kept.
- R8: A `cycle_done` strobe on a disabled channel changes neither its address nor its count, and sets no status bit.
- R9: With auto-reload on, the last cycle of channel 2 copies channel 3's address and count, including the operation code, into channel 2. It sets status bit 2 and the update flag, and channel 2 stays enabled.
- R10: The update flag clears at the next completed cycle of channel 2 after the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| reg_sel | input | 4 | Register select |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the current `reg_sel` |
| cycle_done | input | 4 | Per-channel completed-transfer strobe |
| sel_chan | input | 2 | Channel shown on the current outputs |
| cur_addr | output | 16 | Address of the selected channel |
| cur_op | output | 2 | Operation code of the selected channel |
| tc_out | output | 1 | Selected channel is enabled and on its last cycle |

## Verification
The bench builds the block with its default parameters: four channels, channel 3 as the reload source and channel 2 as the reload target. With these values the reload path and the shared status register come into play, next to an ordinary channel that counts down to its stop. A count of 2 gives a three-cycle run, which lets the bench reach the zero-count indication, the stop and a strobe that is ignored afterwards. A one-cycle channel 2 backed by a five-cycle channel 3 reaches the reload and the clearing of the update flag within a few strobes.

// File: rtl/dmatc_pkg.sv
package dmatc_pkg;

    localparam int NCH_DEF = 4;
    localparam int WORD_W  = 16;
    localparam int CYC_W   = 14;
    localparam logic [3:0] SEL_MODE = 4'h8;

    typedef enum logic [1:0] {
        OP_VERIFY  = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ILLEGAL = 2'b11
    } op_e;

    typedef struct packed {
        logic [2:0] pad;
        logic       upd;
        logic [3:0] tc;
    } stat_t;

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] v, input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

endpackage

// File: rtl/dmatc_toggle.sv
module dmatc_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flip,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) hi <= 1'b0;
        else if (flip)  hi <= ~hi;
    end

    assert_mode_clears_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> !hi);
    assert_access_flips_R2: assert property (@(posedge clk) disable iff (rst)
        (flip && !clr) |=> hi != $past(hi));
endmodule

// File: rtl/dmatc_chan.sv
module dmatc_chan
    import dmatc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_hi,
    input  logic [7:0]        wdata,
    input  logic              step,
    input  logic              reload,
    input  logic [WORD_W-1:0] src_addr,
    input  logic [WORD_W-1:0] src_cnt,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] cnt,
    output logic              at_zero
);
    assign at_zero = (cnt[CYC_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
        end else begin
            if (reload) begin
                addr <= src_addr;
                cnt  <= src_cnt;
            end else if (step) begin
                addr <= addr + 1'b1;
                if (!at_zero) cnt[CYC_W-1:0] <= cnt[CYC_W-1:0] - 1'b1;
            end
            if (wr_addr) begin
                if (wr_hi) addr[15:8] <= wdata;
                else       addr[7:0]  <= wdata;
            end
            if (wr_cnt) begin
                if (wr_hi) cnt[15:8] <= wdata;
                else       cnt[7:0]  <= wdata;
            end
        end
    end

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && !wr_addr) |=> addr == $past(addr) + 16'd1);
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && !wr_cnt && !at_zero) |=>
        (cnt[CYC_W-1:0] == $past(cnt[CYC_W-1:0]) - 14'd1) &&
        (cnt[15:14] == $past(cnt[15:14])));
    assert_reload_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (reload && !wr_addr) |=> addr == $past(src_addr));
endmodule

// File: rtl/dma_tc_unit.sv
module dma_tc_unit
    import dmatc_pkg::*;
#(
    parameter int NCH      = NCH_DEF,
    parameter int CH_W     = $clog2(NCH),
    parameter int AUTO_DST = 2,
    parameter int AUTO_SRC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_sel,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NCH-1:0]    cycle_done,
    input  logic [CH_W-1:0]   sel_chan,
    output logic [WORD_W-1:0] cur_addr,
    output logic [1:0]        cur_op,
    output logic              tc_out
);
    logic              is_mode, is_cnt, hi, chan_acc, mode_wr, stat_rd, reload, autold, upd;
    logic [1:0]        ch_idx;
    logic [NCH-1:0]    en, step, at_zero, done_tc, keep_on, tc_stat;
    logic [WORD_W-1:0] addr_a [NCH];
    logic [WORD_W-1:0] cnt_a  [NCH];
    stat_t             stat;
    op_e               sel_op;

    assign is_mode  = (reg_sel == SEL_MODE);
    assign is_cnt   = reg_sel[0];
    assign ch_idx   = reg_sel[2:1];
    assign chan_acc = !reg_sel[3] && (reg_wr || reg_rd);
    assign mode_wr  = reg_wr && is_mode;
    assign stat_rd  = reg_rd && is_mode;

    assign step    = en & cycle_done;
    assign done_tc = step & at_zero;
    assign reload  = autold && done_tc[AUTO_DST];

    always_comb begin
        keep_on = '0;
        keep_on[AUTO_DST] = reload;
    end

    dmatc_toggle i_toggle (
        .clk(clk), .rst(rst), .clr(mode_wr), .flip(chan_acc), .hi(hi)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel_me;
        assign sel_me = reg_wr && !reg_sel[3] && (ch_idx == 2'(c));
        dmatc_chan i_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_addr (sel_me && !is_cnt),
            .wr_cnt  (sel_me && is_cnt),
            .wr_hi   (hi),
            .wdata   (wdata),
            .step    (step[c]),
            .reload  ((c == AUTO_DST) && reload),
            .src_addr(addr_a[AUTO_SRC]),
            .src_cnt (cnt_a[AUTO_SRC]),
            .addr    (addr_a[c]),
            .cnt     (cnt_a[c]),
            .at_zero (at_zero[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= '0;
            autold  <= 1'b0;
            tc_stat <= '0;
            upd     <= 1'b0;
        end else begin
            en <= en & ~(done_tc & ~keep_on);
            if (mode_wr) begin
                en     <= wdata[NCH-1:0];
                autold <= wdata[4];
            end
            if (stat_rd) tc_stat <= done_tc;
            else         tc_stat <= tc_stat | done_tc;
            if (reload)                upd <= 1'b1;
            else if (step[AUTO_DST])   upd <= 1'b0;
        end
    end

    always_comb begin
        stat     = '0;
        stat.tc  = 4'(tc_stat);
        stat.upd = upd;
        if (is_mode) rdata = stat;
        else         rdata = pick_byte(is_cnt ? cnt_a[ch_idx] : addr_a[ch_idx], hi);
    end

    assign sel_op   = op_e'(cnt_a[sel_chan][15:14]);
    assign cur_op   = sel_op;
    assign cur_addr = addr_a[sel_chan];
    assign tc_out   = en[sel_chan] && at_zero[sel_chan];

    assert_stop_at_tc_R5: assert property (@(posedge clk) disable iff (rst)
        (done_tc[0] && !mode_wr) |=> !en[0]);
    assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (en == '0 && !mode_wr && !stat_rd) |=> $stable(tc_stat));
    assert_reload_flag_R9: assert property (@(posedge clk) disable iff (rst)
        reload |=> (upd && tc_stat[AUTO_DST]));
    assert_upd_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (upd && step[AUTO_DST] && !reload) |=> !upd);
endmodule

// File: tb/test_dma_tc_unit.sv
module test_dma_tc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  cycle_done = '0;
    logic [1:0]  sel_chan = '0;
    logic [15:0] cur_addr;
    logic [1:0]  cur_op;
    logic        tc_out;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_tc_unit i_dma_tc_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .cycle_done(cycle_done), .sel_chan(sel_chan),
        .cur_addr(cur_addr), .cur_op(cur_op), .tc_out(tc_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] sel, input logic [15:0] d);
        wr(sel, d[7:0]); wr(sel, d[15:8]);
    endtask

    task automatic rd(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_sel = sel; #1 d = rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] sel, output logic [15:0] d);
        logic [7:0] lo, hb;
        rd(sel, lo); rd(sel, hb); d = {hb, lo};
    endtask

    task automatic pulse(input int ch);
        @(negedge clk); cycle_done[ch] = 1'b1;
        @(negedge clk); cycle_done = '0; #1;
    endtask

    task automatic t_reset;
        logic [7:0] s; logic [15:0] v;
        rd(4'h8, s);    chk("R1 status", {8'h0, s}, 16'h0);
        rd16(4'h0, v);  chk("R1 ch0 address", v, 16'h0);
        rd16(4'h7, v);  chk("R1 ch3 count", v, 16'h0);
        chk("R1 tc_out", {15'h0, tc_out}, 16'h0);
    endtask

    task automatic t_write_read;
        logic [15:0] v;
        wr(4'h8, 8'h00);
        wr16(4'h2, 16'h1234);
        rd16(4'h2, v); chk("R2 ch1 address readback", v, 16'h1234);
        wr16(4'h3, 16'hC00F);
        rd16(4'h3, v); chk("R2 ch1 count readback", v, 16'hC00F);
        sel_chan = 2'd1; #1;
        chk("R6 illegal op code", {14'h0, cur_op}, 16'h3);
    endtask

    task automatic t_toggle;
        logic [15:0] v;
        wr(4'h0, 8'hAA);
        wr(4'h8, 8'h00);
        wr16(4'h0, 16'h6655);
        rd16(4'h0, v); chk("R3 mode write resets toggle", v, 16'h6655);
    endtask

    task automatic t_count;
        logic [15:0] v; logic [7:0] s;
        wr(4'h8, 8'h00);
        wr16(4'h0, 16'h0100);
        wr16(4'h1, 16'h4002);
        wr(4'h8, 8'h01);
        sel_chan = 2'd0; #1;
        chk("R6 write op code", {14'h0, cur_op}, 16'h1);
        chk("R5 tc_out low at start", {15'h0, tc_out}, 16'h0);
        pulse(0);
        chk("R4 address step", cur_addr, 16'h0101);
        rd16(4'h1, v); chk("R4 count step keeps op", v, 16'h4001);
        pulse(0);
        chk("R5 tc_out on last cycle", {15'h0, tc_out}, 16'h1);
        pulse(0);
        chk("R4 third step address", cur_addr, 16'h0103);
        chk("R5 tc_out off after stop", {15'h0, tc_out}, 16'h0);
        pulse(0);
        chk("R5 stopped channel ignores strobe", cur_addr, 16'h0103);
        rd(4'h8, s); chk("R7 status tc bit 0", {8'h0, s}, 16'h0001);
        rd(4'h8, s); chk("R7 status cleared by read", {8'h0, s}, 16'h0000);
    endtask

    task automatic t_disabled;
        logic [15:0] v; logic [7:0] s;
        pulse(1);
        rd16(4'h2, v); chk("R8 disabled address held", v, 16'h1234);
        rd16(4'h3, v); chk("R8 disabled count held", v, 16'hC00F);
        rd(4'h8, s);   chk("R8 no status bit", {8'h0, s}, 16'h0);
    endtask

    task automatic t_autoload;
        logic [15:0] v; logic [7:0] s;
        wr(4'h8, 8'h00);
        wr16(4'h6, 16'h8000);
        wr16(4'h7, 16'h8004);
        wr16(4'h4, 16'h2000);
        wr16(4'h5, 16'h0000);
        wr(4'h8, 8'h1C);
        sel_chan = 2'd2; #1;
        chk("R5 ch2 tc_out one-cycle load", {15'h0, tc_out}, 16'h1);
        chk("R6 verify op code", {14'h0, cur_op}, 16'h0);
        pulse(2);
        chk("R9 reload address", cur_addr, 16'h8000);
        chk("R9 reload op code", {14'h0, cur_op}, 16'h2);
        rd16(4'h5, v); chk("R9 reload count", v, 16'h8004);
        rd(4'h8, s);   chk("R9 status tc2 and update", {8'h0, s}, 16'h0014);
        pulse(2);
        chk("R9 ch2 still enabled", cur_addr, 16'h8001);
        rd(4'h8, s);   chk("R10 update flag cleared", {8'h0, s}, 16'h0000);
        rd16(4'h5, v); chk("R4 reloaded count steps", v, 16'h8003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_toggle();
        t_count();
        t_disabled();
        t_autoload();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule